// File: doc/BRIEF.md
# Exception Entry Sequencer

This block sits beside a processor pipeline and takes over whenever the core must trap. Every cycle it looks at a synchronous exception request (a major cause code with a subcode, plus a flag marking a translation-refill miss), a debug-breakpoint request, the level-sensitive interrupt lines and the address of the instruction being retired. It decides which of these wins, saves the interrupted context and produces a redirect target for the fetch unit on `next_pc_o`, pulsing `redirect_o` in the cycle the new target is valid.

There are three separate entry routes. A normal trap or an interrupt saves the old mode into the previous-mode fields and the faulting address into the return address, and then vectors through a base address with a programmable slot spacing. A refill miss saves the old mode into its own pair of fields, forces direct addressing and jumps to a dedicated refill base. A debug entry saves the address into a debug return register, raises the debug-state flag and lands at a fixed offset above the base. A one-cycle return strobe undoes the most recent entry, so that nested entry and exit can be exercised. Configuration (mode, interrupt enables, slot spacing, both bases) is written through a small select/data write port.

Top module: `exc_entry_seq`

## Requirements
- R1: The interrupt-status field samples `irq_i` (13 lines, bit n is line n) on every clock edge; an interrupt is pending when that registered status ANDed with the line-enable mask (written with `csr_sel_i`=1, bits 12:0) is nonzero.
- R2: A pending interrupt is taken only while the interrupt-enable bit is 1 and the debug-state flag is 0; the cycle after a take `irq_taken_o` is 1 for one cycle.
- R3: When several enabled lines are pending, the highest-numbered one is taken.
- R4: The slot spacing is 4 << VS bytes with VS in `csr_sel_i`=1 write bits 18:16; a VS of 0 sends every cause to the base address itself.
- R5: An interrupt on line n redirects to base + (64 + n) * spacing and records cause code 0, subcode 0; any other non-refill trap redirects to base + code * spacing. The base is written with `csr_sel_i`=2. The target appears on `next_pc_o` one clock after the request, together with a one-cycle `redirect_o`.
- R6: A normal trap or interrupt copies privilege and interrupt enable into `pplv_o`/`pie_o`, saves `pc_i` into `era_o`, writes code and subcode into `ecode_o`/`esub_o`, and clears privilege and interrupt enable. The mode write (`csr_sel_i`=0) uses bits 1:0 privilege, bit 2 interrupt enable, bit 3 direct addressing, bit 4 paging.
- R7: A request with `refill_i`=1 saves privilege and interrupt enable into `rplv_o`/`rie_o`, saves `pc_i` into `rera_o`, forces direct addressing 1 and paging 0, clears privilege and interrupt enable, leaves the cause fields unchanged, and redirects to the refill base written with `csr_sel_i`=3.
- R8: A debug breakpoint saves `pc_i` into `dera_o`, sets `dst_o` and redirects to base + 0x480 without touching the mode; a trap with cause code 12 taken while `dst_o` is 1 takes the same route and also sets `dei_o`.
- R9: A trap with cause code 8 (fetch address fault) latches `pc_i` into `badv_o`; every other cause, including code 9 (data address fault), leaves `badv_o` unchanged.
- R10: After reset: `next_pc_o`=0x1C000000, privilege 0, interrupt enable 0, direct addressing 1, paging 0, VS 0, all line enables 0, debug state 0.
- R11: `ret_i` outside debug state restores privilege and interrupt enable from the previous-mode fields and redirects to `era_o`; inside debug state it redirects to `dera_o` and clears `dst_o` and `dei_o`.
- R12: Requests in the same cycle are served in the order debug, trap (refill or normal), interrupt, return, configuration write; the losers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 13 | Interrupt line levels |
| exc_req_i | input | 1 | Trap request |
| exc_code_i | input | 6 | Major cause code of the trap |
| exc_sub_i | input | 9 | Cause subcode |
| refill_i | input | 1 | Trap is a translation-refill miss |
| dbg_bp_i | input | 1 | Debug breakpoint request |
| pc_i | input | 32 | Address of the instruction being retired |
| ret_i | input | 1 | Return-from-trap strobe |
| csr_we_i | input | 1 | Configuration write enable |
| csr_sel_i | input | 2 | Write target: 0 mode, 1 enables/spacing, 2 base, 3 refill base |
| csr_wdata_i | input | 32 | Write data |
| next_pc_o | output | 32 | Redirect target / current fetch address |
| redirect_o | output | 1 | One-cycle pulse when next_pc_o was loaded by an entry or return |
| irq_taken_o | output | 1 | One-cycle pulse after an interrupt entry |
| plv_o | output | 2 | Current privilege level |
| ie_o | output | 1 | Current interrupt enable |
| da_o | output | 1 | Direct-addressing mode |
| pg_o | output | 1 | Paging mode |
| pplv_o | output | 2 | Saved privilege, normal entries |
| pie_o | output | 1 | Saved interrupt enable, normal entries |
| rplv_o | output | 2 | Saved privilege, refill entries |
| rie_o | output | 1 | Saved interrupt enable, refill entries |
| ecode_o | output | 6 | Recorded cause code |
| esub_o | output | 9 | Recorded subcode |
| era_o | output | 32 | Return address, normal entries |
| rera_o | output | 32 | Return address, refill entries |
| badv_o | output | 32 | Faulting fetch address |
| dera_o | output | 32 | Return address, debug entries |
| dst_o | output | 1 | Debug state |
| dei_o | output | 1 | Breakpoint taken inside debug state |

## Verification
A wrong internal state shows up at the ports within one or two clocks: a bad priority pick or spacing appears as a wrong `next_pc_o` in the cycle after the request, and a wrong saved mode appears in the previous-mode outputs at once and again as a wrong privilege after the next return. A stale status sample or a broken enable gate shows as an interrupt taken one cycle early, one cycle late, or while debug state is held, which the per-clock comparison against the behavioural model catches in that same cycle. Refill and debug entries are checked for leaving the cause fields and the mode untouched respectively.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_CFG    = 2'd1,
    SEL_BASE   = 2'd2,
    SEL_REFILL = 2'd3
  } csr_sel_e;

  typedef enum logic [2:0] {
    P_IDLE    = 3'd0,
    P_DBG     = 3'd1,
    P_REFILL  = 3'd2,
    P_EXC     = 3'd3,
    P_INT     = 3'd4,
    P_RET_DBG = 3'd5,
    P_RET     = 3'd6
  } path_e;

  // Mode write field positions
  localparam int MODE_PLV_LSB = 0;
  localparam int MODE_IE_BIT  = 2;
  localparam int MODE_DA_BIT  = 3;
  localparam int MODE_PG_BIT  = 4;
  localparam int CFG_VS_LSB   = 16;

endpackage

// File: rtl/exc_irq_arb.sv
module exc_irq_arb #(
  parameter int IRQ_W = 13,
  localparam int LINE_W = $clog2(IRQ_W)
) (
  input  logic [IRQ_W-1:0]  status_i,
  input  logic [IRQ_W-1:0]  enable_i,
  output logic              pend_o,
  output logic [LINE_W-1:0] line_o
);

  logic [IRQ_W-1:0] live;

  assign live   = status_i & enable_i;
  assign pend_o = |live;

  // Ascending scan: the last hit is the highest line
  always_comb begin
    line_o = '0;
    for (int i = 0; i < IRQ_W; i++) begin
      if (live[i]) line_o = LINE_W'(i);
    end
  end

endmodule

// File: rtl/exc_path_sel.sv
module exc_path_sel
  import exc_seq_pkg::*;
(
  input  logic  dbg_bp_i,
  input  logic  exc_req_i,
  input  logic  refill_i,
  input  logic  brk_i,
  input  logic  dst_i,
  input  logic  int_ok_i,
  input  logic  ret_i,
  output path_e path_o,
  output logic  dei_set_o
);

  always_comb begin
    dei_set_o = 1'b0;
    if (dbg_bp_i) begin
      path_o = P_DBG;
    end else if (exc_req_i && brk_i && dst_i) begin
      path_o    = P_DBG;
      dei_set_o = 1'b1;
    end else if (exc_req_i && refill_i) begin
      path_o = P_REFILL;
    end else if (exc_req_i) begin
      path_o = P_EXC;
    end else if (int_ok_i) begin
      path_o = P_INT;
    end else if (ret_i) begin
      path_o = dst_i ? P_RET_DBG : P_RET;
    end else begin
      path_o = P_IDLE;
    end
  end

endmodule

// File: rtl/exc_vec_calc.sv
module exc_vec_calc
  import exc_seq_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int VS_W     = 3,
  parameter int ECODE_W  = 6,
  parameter int LINE_W   = 4,
  parameter int INT_BASE = 64,
  parameter logic [XLEN-1:0] DBG_OFFSET = 'h480
) (
  input  path_e             path_i,
  input  logic [XLEN-1:0]   base_i,
  input  logic [XLEN-1:0]   refill_base_i,
  input  logic [XLEN-1:0]   era_i,
  input  logic [XLEN-1:0]   dera_i,
  input  logic [VS_W-1:0]   vs_i,
  input  logic [ECODE_W-1:0] code_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [XLEN-1:0]   target_o
);

  logic [XLEN-1:0] idx;
  logic [XLEN-1:0] slot_off;

  always_comb begin
    idx      = (path_i == P_INT) ? XLEN'(INT_BASE) + XLEN'(line_i) : XLEN'(code_i);
    // VS of zero collapses every slot onto the base
    slot_off = (vs_i == '0) ? '0 : idx << (32'(vs_i) + 32'd2);
    unique case (path_i)
      P_DBG:        target_o = base_i + DBG_OFFSET;
      P_REFILL:     target_o = refill_base_i;
      P_EXC, P_INT: target_o = base_i + slot_off;
      P_RET_DBG:    target_o = dera_i;
      P_RET:        target_o = era_i;
      default:      target_o = base_i;
    endcase
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int IRQ_W      = 13,
  parameter int ECODE_W    = 6,
  parameter int ESUB_W     = 9,
  parameter int VS_W       = 3,
  parameter int INT_BASE   = 64,
  parameter int BRK_CODE   = 12,
  parameter int FETCH_CODE = 8,
  parameter logic [XLEN-1:0] RESET_PC   = 32'h1C00_0000,
  parameter logic [XLEN-1:0] DBG_OFFSET = 'h480
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IRQ_W-1:0]   irq_i,
  input  logic               exc_req_i,
  input  logic [ECODE_W-1:0] exc_code_i,
  input  logic [ESUB_W-1:0]  exc_sub_i,
  input  logic               refill_i,
  input  logic               dbg_bp_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic               ret_i,
  input  logic               csr_we_i,
  input  logic [1:0]         csr_sel_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    next_pc_o,
  output logic               redirect_o,
  output logic               irq_taken_o,
  output logic [1:0]         plv_o,
  output logic               ie_o,
  output logic               da_o,
  output logic               pg_o,
  output logic [1:0]         pplv_o,
  output logic               pie_o,
  output logic [1:0]         rplv_o,
  output logic               rie_o,
  output logic [ECODE_W-1:0] ecode_o,
  output logic [ESUB_W-1:0]  esub_o,
  output logic [XLEN-1:0]    era_o,
  output logic [XLEN-1:0]    rera_o,
  output logic [XLEN-1:0]    badv_o,
  output logic [XLEN-1:0]    dera_o,
  output logic               dst_o,
  output logic               dei_o
);

  localparam int LINE_W = $clog2(IRQ_W);

  // State
  logic [XLEN-1:0]    pc_q, era_q, rera_q, badv_q, dera_q, base_q, rbase_q;
  logic [1:0]         plv_q, pplv_q, rplv_q;
  logic               ie_q, pie_q, rie_q, da_q, pg_q, dst_q, dei_q;
  logic [ECODE_W-1:0] ecode_q;
  logic [ESUB_W-1:0]  esub_q;
  logic [IRQ_W-1:0]   is_q, lie_q;
  logic [VS_W-1:0]    vs_q;
  logic               redirect_q, taken_q;

  // Decision
  logic              pend, int_ok, brk_hit, dei_set;
  logic [LINE_W-1:0] line;
  path_e             path;
  logic [XLEN-1:0]   target;
  csr_sel_e          sel;

  assign sel     = csr_sel_e'(csr_sel_i);
  assign int_ok  = ie_q & ~dst_q & pend;
  assign brk_hit = (exc_code_i == ECODE_W'(BRK_CODE));

  exc_irq_arb #(.IRQ_W(IRQ_W)) u_arb (
    .status_i (is_q),
    .enable_i (lie_q),
    .pend_o   (pend),
    .line_o   (line)
  );

  exc_path_sel u_sel (
    .dbg_bp_i  (dbg_bp_i),
    .exc_req_i (exc_req_i),
    .refill_i  (refill_i),
    .brk_i     (brk_hit),
    .dst_i     (dst_q),
    .int_ok_i  (int_ok),
    .ret_i     (ret_i),
    .path_o    (path),
    .dei_set_o (dei_set)
  );

  exc_vec_calc #(
    .XLEN       (XLEN),
    .VS_W       (VS_W),
    .ECODE_W    (ECODE_W),
    .LINE_W     (LINE_W),
    .INT_BASE   (INT_BASE),
    .DBG_OFFSET (DBG_OFFSET)
  ) u_vec (
    .path_i        (path),
    .base_i        (base_q),
    .refill_base_i (rbase_q),
    .era_i         (era_q),
    .dera_i        (dera_q),
    .vs_i          (vs_q),
    .code_i        (exc_code_i),
    .line_i        (line),
    .target_o      (target)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= RESET_PC;
      era_q      <= '0;
      rera_q     <= '0;
      badv_q     <= '0;
      dera_q     <= '0;
      base_q     <= '0;
      rbase_q    <= '0;
      plv_q      <= '0;
      pplv_q     <= '0;
      rplv_q     <= '0;
      ie_q       <= 1'b0;
      pie_q      <= 1'b0;
      rie_q      <= 1'b0;
      da_q       <= 1'b1;
      pg_q       <= 1'b0;
      dst_q      <= 1'b0;
      dei_q      <= 1'b0;
      ecode_q    <= '0;
      esub_q     <= '0;
      is_q       <= '0;
      lie_q      <= '0;
      vs_q       <= '0;
      redirect_q <= 1'b0;
      taken_q    <= 1'b0;
    end else begin
      is_q       <= irq_i;
      redirect_q <= (path != P_IDLE);
      taken_q    <= (path == P_INT);
      if (path != P_IDLE) pc_q <= target;
      unique case (path)
        P_DBG: begin
          dera_q <= pc_i;
          dst_q  <= 1'b1;
          if (dei_set) dei_q <= 1'b1;
        end
        P_REFILL: begin
          rplv_q <= plv_q;
          rie_q  <= ie_q;
          rera_q <= pc_i;
          da_q   <= 1'b1;
          pg_q   <= 1'b0;
          plv_q  <= '0;
          ie_q   <= 1'b0;
        end
        P_EXC, P_INT: begin
          pplv_q  <= plv_q;
          pie_q   <= ie_q;
          era_q   <= pc_i;
          plv_q   <= '0;
          ie_q    <= 1'b0;
          ecode_q <= (path == P_INT) ? '0 : exc_code_i;
          esub_q  <= (path == P_INT) ? '0 : exc_sub_i;
          if (path == P_EXC && exc_code_i == ECODE_W'(FETCH_CODE)) badv_q <= pc_i;
        end
        P_RET_DBG: begin
          dst_q <= 1'b0;
          dei_q <= 1'b0;
        end
        P_RET: begin
          plv_q <= pplv_q;
          ie_q  <= pie_q;
        end
        default: begin
          if (csr_we_i) begin
            unique case (sel)
              SEL_MODE: begin
                plv_q <= csr_wdata_i[MODE_PLV_LSB +: 2];
                ie_q  <= csr_wdata_i[MODE_IE_BIT];
                da_q  <= csr_wdata_i[MODE_DA_BIT];
                pg_q  <= csr_wdata_i[MODE_PG_BIT];
              end
              SEL_CFG: begin
                lie_q <= csr_wdata_i[IRQ_W-1:0];
                vs_q  <= csr_wdata_i[CFG_VS_LSB +: VS_W];
              end
              SEL_BASE:   base_q  <= csr_wdata_i;
              SEL_REFILL: rbase_q <= csr_wdata_i;
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  assign next_pc_o   = pc_q;
  assign redirect_o  = redirect_q;
  assign irq_taken_o = taken_q;
  assign plv_o       = plv_q;
  assign ie_o        = ie_q;
  assign da_o        = da_q;
  assign pg_o        = pg_q;
  assign pplv_o      = pplv_q;
  assign pie_o       = pie_q;
  assign rplv_o      = rplv_q;
  assign rie_o       = rie_q;
  assign ecode_o     = ecode_q;
  assign esub_o      = esub_q;
  assign era_o       = era_q;
  assign rera_o      = rera_q;
  assign badv_o      = badv_q;
  assign dera_o      = dera_q;
  assign dst_o       = dst_q;
  assign dei_o       = dei_q;

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] next_pc_o,
  input logic            redirect_o,
  input logic            irq_taken_o,
  input logic [1:0]      plv_o,
  input logic            ie_o,
  input logic            pie_o,
  input logic            da_o,
  input logic            pg_o,
  input logic [XLEN-1:0] dera_o,
  input logic            dst_o
);

  assert_take_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_taken_o |-> ($past(ie_o) && !$past(dst_o)));

  assert_entry_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_taken_o |-> (!ie_o && plv_o == 2'd0 && pie_o && redirect_o));

  assert_refill_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && da_o && !$past(da_o)) |-> !pg_o);

  assert_dbg_save_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dst_o) |-> (redirect_o && dera_o == $past(pc_i)));

  assert_dbg_exit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dst_o) |-> (redirect_o && next_pc_o == dera_o));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.XLEN(XLEN)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pc_i        (pc_i),
  .next_pc_o   (next_pc_o),
  .redirect_o  (redirect_o),
  .irq_taken_o (irq_taken_o),
  .plv_o       (plv_o),
  .ie_o        (ie_o),
  .pie_o       (pie_o),
  .da_o        (da_o),
  .pg_o        (pg_o),
  .dera_o      (dera_o),
  .dst_o       (dst_o)
);

// File: tb/sim_exc_entry_seq.sv
`timescale 1ns/1ps
module sim_exc_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] irq = '0;
  logic        exc_req = 1'b0;
  logic [5:0]  exc_code = '0;
  logic [8:0]  exc_sub = '0;
  logic        refill = 1'b0;
  logic        dbg_bp = 1'b0;
  logic [31:0] pc_in = '0;
  logic        ret = 1'b0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_sel = '0;
  logic [31:0] csr_wdata = '0;

  logic [31:0] next_pc, era, rera, badv, dera;
  logic        redirect, irq_taken, ie, da, pg, pie, rie, dst, dei;
  logic [1:0]  plv, pplv, rplv;
  logic [5:0]  ecode;
  logic [8:0]  esub;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  exc_entry_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .exc_req_i(exc_req),
    .exc_code_i(exc_code), .exc_sub_i(exc_sub), .refill_i(refill),
    .dbg_bp_i(dbg_bp), .pc_i(pc_in), .ret_i(ret), .csr_we_i(csr_we),
    .csr_sel_i(csr_sel), .csr_wdata_i(csr_wdata), .next_pc_o(next_pc),
    .redirect_o(redirect), .irq_taken_o(irq_taken), .plv_o(plv), .ie_o(ie),
    .da_o(da), .pg_o(pg), .pplv_o(pplv), .pie_o(pie), .rplv_o(rplv),
    .rie_o(rie), .ecode_o(ecode), .esub_o(esub), .era_o(era), .rera_o(rera),
    .badv_o(badv), .dera_o(dera), .dst_o(dst), .dei_o(dei)
  );

  // Behavioural reference model
  logic [31:0] m_pc, m_era, m_rera, m_badv, m_dera, m_base, m_rbase;
  logic [1:0]  m_plv, m_pplv, m_rplv;
  logic        m_ie, m_pie, m_rie, m_da, m_pg, m_dst, m_dei, m_redir, m_taken;
  logic [5:0]  m_ecode;
  logic [8:0]  m_esub;
  logic [12:0] m_is, m_lie;
  int          m_vs;

  function automatic logic [31:0] slot(int idx, int vs);
    if (vs == 0) return 32'd0;
    return 32'(idx) * (32'd4 << vs);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 32'h1C00_0000; m_era = 0; m_rera = 0; m_badv = 0; m_dera = 0;
      m_base = 0; m_rbase = 0; m_plv = 0; m_pplv = 0; m_rplv = 0;
      m_ie = 0; m_pie = 0; m_rie = 0; m_da = 1; m_pg = 0; m_dst = 0; m_dei = 0;
      m_redir = 0; m_taken = 0; m_ecode = 0; m_esub = 0; m_is = 0; m_lie = 0; m_vs = 0;
    end else begin
      int line;
      line = -1;
      for (int i = 0; i < 13; i++) if (m_is[i] && m_lie[i]) line = i;
      m_redir = 1; m_taken = 0;
      if (dbg_bp || (exc_req && exc_code == 6'd12 && m_dst)) begin
        if (!dbg_bp) m_dei = 1;
        m_dera = pc_in; m_dst = 1; m_pc = m_base + 32'h480;
      end else if (exc_req && refill) begin
        m_rplv = m_plv; m_rie = m_ie; m_rera = pc_in;
        m_da = 1; m_pg = 0; m_plv = 0; m_ie = 0; m_pc = m_rbase;
      end else if (exc_req || (m_ie && !m_dst && line >= 0)) begin
        m_pplv = m_plv; m_pie = m_ie; m_era = pc_in; m_plv = 0; m_ie = 0;
        if (exc_req) begin
          m_ecode = exc_code; m_esub = exc_sub;
          if (exc_code == 6'd8) m_badv = pc_in;
          m_pc = m_base + slot(int'(exc_code), m_vs);
        end else begin
          m_ecode = 0; m_esub = 0; m_taken = 1;
          m_pc = m_base + slot(64 + line, m_vs);
        end
      end else if (ret) begin
        if (m_dst) begin
          m_pc = m_dera; m_dst = 0; m_dei = 0;
        end else begin
          m_pc = m_era; m_plv = m_pplv; m_ie = m_pie;
        end
      end else begin
        m_redir = 0;
        if (csr_we) begin
          case (csr_sel)
            2'd0: begin m_plv = csr_wdata[1:0]; m_ie = csr_wdata[2]; m_da = csr_wdata[3]; m_pg = csr_wdata[4]; end
            2'd1: begin m_lie = csr_wdata[12:0]; m_vs = int'(csr_wdata[18:16]); end
            2'd2: m_base = csr_wdata;
            default: m_rbase = csr_wdata;
          endcase
        end
      end
      m_is = irq;
    end
  end

  task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cmp("R5",  "next_pc",  next_pc, m_pc);
      cmp("R5",  "redirect", 32'(redirect), 32'(m_redir));
      cmp("R2",  "irq_taken", 32'(irq_taken), 32'(m_taken));
      cmp("R6",  "plv/ie",   {plv, ie}, {m_plv, m_ie});
      cmp("R6",  "saved",    {pplv, pie, era}, {m_pplv, m_pie, m_era});
      cmp("R6",  "cause",    {ecode, esub}, {m_ecode, m_esub});
      cmp("R7",  "da/pg",    {da, pg}, {m_da, m_pg});
      cmp("R7",  "refill",   {rplv, rie, rera}, {m_rplv, m_rie, m_rera});
      cmp("R8",  "dbg",      {dst, dei, dera}, {m_dst, m_dei, m_dera});
      cmp("R9",  "badv",     badv, m_badv);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic csr_wr(logic [1:0] s, logic [31:0] d);
    csr_we = 1; csr_sel = s; csr_wdata = d; tick(); csr_we = 0;
  endtask

  task automatic trap(logic [5:0] c, logic [8:0] s, logic r);
    exc_req = 1; exc_code = c; exc_sub = s; refill = r; tick();
    exc_req = 0; refill = 0;
  endtask

  task automatic do_ret(); ret = 1; tick(); ret = 0; endtask

  initial begin
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R10 reset state
    cmp("R10", "reset pc", next_pc, 32'h1C00_0000);
    cmp("R10", "reset mode", {plv, ie, da, pg, dst}, {2'd0, 1'b0, 1'b1, 1'b0, 1'b0});

    csr_wr(2'd2, 32'h0000_8000);
    csr_wr(2'd3, 32'h0000_4000);
    csr_wr(2'd1, (32'd3 << 16) | 32'h088);
    pc_in = 32'h1000_0100;
    irq = 13'h088;
    repeat (3) tick();
    // R2 no take with interrupts disabled
    cmp("R2", "gated pc", next_pc, 32'h1C00_0000);

    csr_wr(2'd0, 32'h7);           // plv 3, ie 1, da 0, pg 0
    tick();
    // R3 line 7 beats line 3; R5 target; R6 save
    cmp("R3", "int target", next_pc, 32'h0000_88E0);
    cmp("R6", "int save", {pplv, pie, plv, ie}, {2'd3, 1'b1, 2'd0, 1'b0});
    cmp("R5", "int cause", 32'(ecode), 32'd0);
    irq = '0; tick(); tick();
    do_ret();
    cmp("R11", "ret pc", next_pc, 32'h1000_0100);
    cmp("R11", "ret mode", {plv, ie}, {2'd3, 1'b1});

    // R1/R4: only line 12 enabled, VS 0 -> base
    csr_wr(2'd1, 32'h1000);
    irq = 13'h1003;
    repeat (3) tick();
    cmp("R4", "vs0 target", next_pc, 32'h0000_8000);
    cmp("R1", "masked lines", 32'(ie), 32'd0);
    irq = '0; tick(); tick();
    do_ret();

    // R5/R6 normal trap, VS 1
    csr_wr(2'd1, 32'd1 << 16);
    pc_in = 32'h1000_0200;
    trap(6'd5, 9'd2, 1'b0);
    cmp("R5", "exc target", next_pc, 32'h0000_8028);
    cmp("R6", "exc cause", {ecode, esub, era}, {6'd5, 9'd2, 32'h1000_0200});
    do_ret();

    // R9 fetch fault latches, data fault does not
    pc_in = 32'h2000_0040;
    trap(6'd8, 9'd0, 1'b0);
    cmp("R9", "fetch badv", badv, 32'h2000_0040);
    cmp("R5", "fetch target", next_pc, 32'h0000_8040);
    do_ret();
    pc_in = 32'h3000_0000;
    trap(6'd9, 9'd1, 1'b0);
    cmp("R9", "data badv", badv, 32'h2000_0040);
    do_ret();

    // R7 refill
    csr_wr(2'd0, 32'h16);          // plv 2, ie 1, da 0, pg 1
    trap(6'd3, 9'd0, 1'b1);
    cmp("R7", "refill pc", next_pc, 32'h0000_4000);
    cmp("R7", "refill mode", {da, pg, rplv, rie}, {1'b1, 1'b0, 2'd2, 1'b1});
    cmp("R7", "refill cause kept", 32'(ecode), 32'd9);
    do_ret();

    // R8 debug entry; R2 gating in debug state
    pc_in = 32'h5000_0000;
    dbg_bp = 1; tick(); dbg_bp = 0;
    cmp("R8", "dbg pc", next_pc, 32'h0000_8480);
    cmp("R8", "dbg save", {dst, dera}, {1'b1, 32'h5000_0000});
    csr_wr(2'd1, (32'd1 << 16) | 32'h4);
    irq = 13'h004;
    repeat (3) tick();
    cmp("R2", "dbg gate", next_pc, 32'h0000_8480);
    pc_in = 32'h5000_0010;
    trap(6'd12, 9'd0, 1'b0);
    cmp("R8", "brk in dbg", {dei, dera, next_pc}, {1'b1, 32'h5000_0010, 32'h0000_8480});
    do_ret();
    cmp("R11", "dbg ret", {dst, dei, next_pc}, {1'b0, 1'b0, 32'h5000_0010});
    tick();
    cmp("R5", "int after dbg", next_pc, 32'h0000_8210);
    irq = '0; tick(); tick();
    do_ret();

    // R12 priority
    irq = 13'h004; tick(); 
    pc_in = 32'h6000_0000;
    exc_req = 1; exc_code = 6'd5; dbg_bp = 1; tick(); exc_req = 0; dbg_bp = 0;
    cmp("R12", "dbg over trap", {dst, ecode, next_pc}, {1'b1, 6'd0, 32'h0000_8480});
    irq = '0; tick(); tick();
    do_ret();
    irq = 13'h004; tick();
    trap(6'd7, 9'd0, 1'b0);
    cmp("R12", "trap over int", {32'(ecode), next_pc}, {32'd7, 32'h0000_8038});
    irq = '0; tick(); tick();
    do_ret();
    tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL R10 watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule